// File: doc/BRIEF.md
# Raster-Op Pixel Mix Unit

This block is the per-pixel colour datapath of a 2D drawing engine. For every destination pixel it receives a source colour, the colour already in the destination, and a one-bit monochrome select. It produces the colour to store and a write-enable. The select bit picks one of two paths, foreground or background, and each path has its own colour operand and its own two-operand raster operation. The result is then merged into the old destination under a per-bit plane mask. An optional colour-key compare can cancel the write, so source pixels of a chosen colour act as transparent.

Software programs the behaviour through a small register file with a single write port. Pixels enter on a valid/ready handshake and leave from one output register, so the latency is one cycle. A stalled consumer holds the output in place and applies back-pressure to the input. The unit does not generate addresses, access memory or convert pixel depth. Those jobs belong to the stages around it.

Top module: `rop_mix_unit`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `in_ready` is 1, and every configuration register is 0. With that configuration, an accepted pixel comes out equal to its destination value, with the write-enable at 1.
- R2: A raster operation is a 4-bit code. Bit `{s,d}` of the code (index 2*s+d) is the result bit for source bit s and destination bit d. Examples: 0x0 clear, 0x8 and, 0x4 src-and-not-dst, 0xC copy, 0x2 not-src-and-dst, 0xA keep destination, 0x6 xor, 0xE or, 0x1 nor, 0x9 xnor, 0x5 invert destination, 0xD src-or-not-dst, 0x3 not source, 0xB not-src-or-dst, 0x7 nand, 0xF set. The code is applied to each bit independently.
- R3: When `in_mono`=1, the foreground operand and the foreground code are used. When `in_mono`=0, the background colour register and the background code are used.
- R4: When the background code is 0xA, a pixel with `in_mono`=0 leaves the destination unchanged.
- R5: The stored pixel is (result & mask) | (dst & ~mask), where mask is the plane-mask register.
- R6: When control bit 0 is 0, the foreground operand is the foreground colour register. When it is 1, the foreground operand is `in_src`.
- R7: When control bit 1 is 1 and `in_src` equals the key colour register, `out_we` is 0 and `out_pix` equals the destination value.
- R8: When control bit 1 is 0, `out_we` is always 1, even when `in_src` equals the key colour.
- R9: A pixel accepted on a clock edge appears with `out_valid`=1 on the next edge. While `out_valid`=1 and `out_ready`=0, the output is held stable and `in_ready` is 0. A new pixel may be accepted on the same edge on which the held pixel is taken.
- R10: A pixel accepted on the same edge as a configuration write is processed with the configuration in force before that write.
- R11: The register addresses are: 0 foreground colour, 1 background colour, 2 plane mask, 3 key colour, 4 codes (foreground in bits 3:0, background in bits 7:4), 5 control. Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | PIX_W | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Unit can accept a pixel |
| in_src | input | PIX_W | Source colour |
| in_dst | input | PIX_W | Current destination colour |
| in_mono | input | 1 | 1 selects foreground path, 0 background |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output |
| out_pix | output | PIX_W | Colour to store |
| out_we | output | 1 | 1 when the pixel is to be written |

## Verification
The case that needs care is a configuration write landing on the same edge as a pixel accept. The bench drives the write strobe and the pixel in one cycle, with the output free, so the accept cannot slip. It then expects the old code on that pixel and the new code on the next pixel. A second collision is the output drain and a new accept on the same edge under back-pressure. This is provoked by releasing `out_ready` from a parallel thread while a second pixel waits. The scoreboard must then see both pixels, in order, with unchanged values.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int CFG_AW = 3;

  localparam logic [CFG_AW-1:0] A_FG   = 3'd0;
  localparam logic [CFG_AW-1:0] A_BG   = 3'd1;
  localparam logic [CFG_AW-1:0] A_MASK = 3'd2;
  localparam logic [CFG_AW-1:0] A_KEY  = 3'd3;
  localparam logic [CFG_AW-1:0] A_MIX  = 3'd4;
  localparam logic [CFG_AW-1:0] A_CTRL = 3'd5;

  typedef logic [3:0] rop_t;

  localparam rop_t ROP_CLEAR = 4'h0;
  localparam rop_t ROP_KEEP  = 4'hA;
  localparam rop_t ROP_COPY  = 4'hC;

  typedef struct packed {
    rop_t fg_rop;
    rop_t bg_rop;
    logic fg_from_src;
    logic key_eq;
  } mode_t;
endpackage

// File: rtl/rop_cfg_regs.sv
module rop_cfg_regs
  import rop_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [PIX_W-1:0]  wdata,
  output logic [PIX_W-1:0]  fg_col,
  output logic [PIX_W-1:0]  bg_col,
  output logic [PIX_W-1:0]  mask,
  output logic [PIX_W-1:0]  key_col,
  output mode_t             mode
);
  // Each register loads only on its own address; unmapped addresses fall through.
  always_ff @(posedge clk) begin
    if (rst) begin
      fg_col  <= '0;
      bg_col  <= '0;
      mask    <= '0;
      key_col <= '0;
      mode    <= '0;
    end else if (we) begin
      case (addr)
        A_FG:   fg_col  <= wdata;
        A_BG:   bg_col  <= wdata;
        A_MASK: mask    <= wdata;
        A_KEY:  key_col <= wdata;
        A_MIX: begin
          mode.fg_rop <= wdata[3:0];
          mode.bg_rop <= wdata[7:4];
        end
        A_CTRL: begin
          mode.fg_from_src <= wdata[0];
          mode.key_eq      <= wdata[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rop_bitwise.sv
module rop_bitwise
  import rop_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  rop_t             rop,
  input  logic [PIX_W-1:0] s,
  input  logic [PIX_W-1:0] d,
  output logic [PIX_W-1:0] r
);
  // Truth-table lookup per bit: the code itself is the four-entry table.
  for (genvar i = 0; i < PIX_W; i++) begin : g_bit
    assign r[i] = rop[{s[i], d[i]}];
  end
endmodule

// File: rtl/rop_key_cmp.sv
module rop_key_cmp #(
  parameter int PIX_W = 32
) (
  input  logic             en,
  input  logic [PIX_W-1:0] src,
  input  logic [PIX_W-1:0] key,
  output logic             veto
);
  assign veto = en && (src == key);
endmodule

// File: rtl/rop_mix_unit.sv
module rop_mix_unit
  import rop_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [PIX_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_src,
  input  logic [PIX_W-1:0]  in_dst,
  input  logic              in_mono,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_we
);
  logic [PIX_W-1:0] fg_q, bg_q, mask_q, key_q;
  mode_t            mode_q;
  logic             key_eq_en;

  rop_cfg_regs #(.PIX_W(PIX_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .fg_col(fg_q), .bg_col(bg_q), .mask(mask_q), .key_col(key_q), .mode(mode_q)
  );

  assign key_eq_en = mode_q.key_eq;

  logic [PIX_W-1:0] fg_opnd, fg_res, bg_res, sel_res, merged;
  logic             veto;

  assign fg_opnd = mode_q.fg_from_src ? in_src : fg_q;

  rop_bitwise #(.PIX_W(PIX_W)) u_fg (
    .rop(mode_q.fg_rop), .s(fg_opnd), .d(in_dst), .r(fg_res)
  );

  rop_bitwise #(.PIX_W(PIX_W)) u_bg (
    .rop(mode_q.bg_rop), .s(bg_q), .d(in_dst), .r(bg_res)
  );

  rop_key_cmp #(.PIX_W(PIX_W)) u_key (
    .en(key_eq_en), .src(in_src), .key(key_q), .veto(veto)
  );

  assign sel_res = in_mono ? fg_res : bg_res;
  assign merged  = (sel_res & mask_q) | (in_dst & ~mask_q);

  logic acc;
  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_we    <= 1'b0;
    end else begin
      if (acc) begin
        out_valid <= 1'b1;
        out_pix   <= veto ? in_dst : merged;
        out_we    <= !veto;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rop_mix_checker.sv
module rop_mix_checker #(
  parameter int PIX_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_src,
  input logic [PIX_W-1:0] in_dst,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_we,
  input logic             key_eq_en,
  input logic [PIX_W-1:0] key_col,
  input logic [PIX_W-1:0] plane_mask
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_accept_latency_r9: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_we)));

  p_mask_merge_r5: assert property (@(posedge clk) disable iff (rst)
    acc |=> (((out_pix ^ $past(in_dst)) & ~$past(plane_mask)) == '0));

  p_key_veto_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && key_eq_en && (in_src == key_col)) |=> (!out_we && out_pix == $past(in_dst)));

  p_no_veto_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && !key_eq_en) |=> out_we);
endmodule

bind rop_mix_unit rop_mix_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
  .out_pix(out_pix), .out_we(out_we), .key_eq_en(key_eq_en),
  .key_col(key_q), .plane_mask(mask_q)
);

// File: tb/sim_rop_mix_unit.sv
`timescale 1ns/1ps
module sim_rop_mix_unit;
  localparam int W = 32;

  logic         clk = 0;
  logic         rst = 1;
  logic         cfg_we = 0;
  logic [2:0]   cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [W-1:0] in_src = '0, in_dst = '0;
  logic         in_mono = 0;
  logic         out_valid;
  logic         out_ready = 1;
  logic [W-1:0] out_pix;
  logic         out_we;

  always #2 clk = ~clk;

  rop_mix_unit #(.PIX_W(W)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_dst(in_dst),
    .in_mono(in_mono), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_we(out_we)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [W-1:0] pix; logic we; string req; } exp_t;
  exp_t exp_q[$];

  // Bench-side model of the configuration
  logic [W-1:0] m_fg = '0, m_bg = '0, m_mask = '0, m_key = '0;
  logic [3:0]   m_fgrop = '0, m_bgrop = '0;
  logic         m_use_src = 0, m_keyeq = 0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] s, input logic [W-1:0] d, input logic m, input string req);
    exp_t e;
    logic [W-1:0] opnd, res;
    logic [3:0] code;
    opnd = m ? (m_use_src ? s : m_fg) : m_bg;
    code = m ? m_fgrop : m_bgrop;
    for (int i = 0; i < W; i++) res[i] = code[{opnd[i], d[i]}];
    e.req = req;
    if (m_keyeq && s == m_key) begin e.pix = d; e.we = 1'b0; end
    else begin e.pix = (res & m_mask) | (d & ~m_mask); e.we = 1'b1; end
    return e;
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [W-1:0] v);
    case (a)
      3'd0: m_fg = v;
      3'd1: m_bg = v;
      3'd2: m_mask = v;
      3'd3: m_key = v;
      3'd4: begin m_fgrop = v[3:0]; m_bgrop = v[7:4]; end
      3'd5: begin m_use_src = v[0]; m_keyeq = v[1]; end
      default: ;
    endcase
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [W-1:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk); #1 cfg_we = 0;
    model_write(a, v);
  endtask

  task automatic send_exp(input logic [W-1:0] s, input logic [W-1:0] d, input logic m, input exp_t e);
    @(negedge clk);
    in_src = s; in_dst = d; in_mono = m; in_valid = 1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(e);
    @(posedge clk); #1 in_valid = 0;
    @(negedge clk);
    check(out_valid === 1'b1, {"R9 latency ", e.req}, {31'd0, out_valid}, 1);
  endtask

  task automatic send(input logic [W-1:0] s, input logic [W-1:0] d, input logic m, input string req);
    send_exp(s, d, m, model(s, d, m, req));
  endtask

  task automatic send_lit(input logic [W-1:0] s, input logic [W-1:0] d, input logic m,
                          input logic [W-1:0] p, input logic we, input string req);
    exp_t e;
    e.pix = p; e.we = we; e.req = req;
    send_exp(s, d, m, e);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R9 unexpected output", out_pix, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_pix === e.pix, {e.req, " pix"}, out_pix, e.pix);
        check(out_we === e.we, {e.req, " we"}, {31'd0, out_we}, {31'd0, e.we});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 1);
    send_lit(32'hFFFF_0000, 32'h1234_5678, 1, 32'h1234_5678, 1, "R1 reset config passes dst");

    // R11 map / R3 foreground path / R4 transparent background
    cfg_write(3'd2, 32'hFFFF_FFFF);
    cfg_write(3'd0, 32'hA5A5_0F0F);
    cfg_write(3'd4, 32'h0000_00AC);
    send_lit(32'h0, 32'h1111_1111, 1, 32'hA5A5_0F0F, 1, "R3 fg colour copy");
    send_lit(32'h0, 32'h2468_ACE0, 0, 32'h2468_ACE0, 1, "R4 bg keep dst");

    // R2: all sixteen codes, fg operand from source
    cfg_write(3'd5, 32'h1);
    for (int c = 0; c < 16; c++) begin
      logic [7:0] b;
      cfg_write(3'd4, {24'd0, 4'hA, c[3:0]});
      b = (c[3] ? 8'hC0 : 8'h00) | (c[2] ? 8'h30 : 8'h00) | (c[1] ? 8'h0C : 8'h00) | (c[0] ? 8'h03 : 8'h00);
      send_lit(32'hF0F0_F0F0, 32'hCCCC_CCCC, 1, {4{b}}, 1, $sformatf("R2 code %0h", c));
    end
    cfg_write(3'd4, 32'h0000_00A6);
    send_lit(32'hFF00_FF00, 32'h0F0F_0F0F, 1, 32'hF00F_F00F, 1, "R2 xor");

    // R3 background path with own colour and code
    cfg_write(3'd1, 32'h0000_FFFF);
    cfg_write(3'd4, 32'h0000_00C0);
    send_lit(32'h1234_5678, 32'h5555_5555, 0, 32'h0000_FFFF, 1, "R3 bg copy");
    send_lit(32'h1234_5678, 32'h5555_5555, 1, 32'h0000_0000, 1, "R3 fg clear");
    cfg_write(3'd4, 32'h0000_0060);
    send(32'h0, 32'h5555_5555, 0, "R3 bg xor");

    // R5 plane mask
    cfg_write(3'd4, 32'h0000_00AC);
    cfg_write(3'd2, 32'h00FF_00FF);
    send_lit(32'hABCD_EF01, 32'h1122_3344, 1, 32'h11CD_3301, 1, "R5 mask merge");
    send(32'h0000_0000, 32'hFFFF_FFFF, 1, "R5 mask zeros");
    cfg_write(3'd2, 32'hFFFF_FFFF);

    // R6 foreground operand select
    cfg_write(3'd5, 32'h0);
    send_lit(32'h0BAD_F00D, 32'h0, 1, 32'hA5A5_0F0F, 1, "R6 fg from register");
    cfg_write(3'd5, 32'h1);
    send_lit(32'h0BAD_F00D, 32'h0, 1, 32'h0BAD_F00D, 1, "R6 fg from source");

    // R7 colour key equal
    cfg_write(3'd3, 32'h1122_3344);
    cfg_write(3'd5, 32'h3);
    send_lit(32'h1122_3344, 32'h9999_9999, 1, 32'h9999_9999, 0, "R7 key match vetoed");
    send_lit(32'h1122_3345, 32'h9999_9999, 1, 32'h1122_3345, 1, "R7 key mismatch written");
    send_lit(32'h1122_3344, 32'h7777_7777, 0, 32'h7777_7777, 0, "R7 key match bg path");

    // R8 compare off
    cfg_write(3'd5, 32'h1);
    send_lit(32'h1122_3344, 32'h9999_9999, 1, 32'h1122_3344, 1, "R8 compare off writes");

    // R11 unmapped addresses ignored
    cfg_write(3'd6, 32'hFFFF_FFFF);
    cfg_write(3'd7, 32'h0000_0000);
    send_lit(32'hCAFE_BABE, 32'h0, 1, 32'hCAFE_BABE, 1, "R11 unmapped writes ignored");

    // R10 config write in the same cycle as accept
    begin
      exp_t e;
      @(negedge clk);
      e = model(32'h5A5A_5A5A, 32'h0, 1, "R10 old config used");
      cfg_we = 1; cfg_addr = 3'd4; cfg_wdata = 32'h0000_00A0;
      in_src = 32'h5A5A_5A5A; in_dst = 32'h0; in_mono = 1; in_valid = 1;
      check(in_ready === 1'b1, "R10 ready for collision", {31'd0, in_ready}, 1);
      exp_q.push_back(e);
      @(posedge clk); #1 in_valid = 0; cfg_we = 0;
      model_write(3'd4, 32'h0000_00A0);
    end
    send_lit(32'h5A5A_5A5A, 32'h0, 1, 32'h0, 1, "R10 new config after");

    // R9 hold under back-pressure, then drain with simultaneous accept
    cfg_write(3'd4, 32'h0000_00AC);
    @(posedge clk); #1 out_ready = 0;
    send(32'h1357_9BDF, 32'h0, 1, "R9 stalled pixel");
    held = out_pix;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_pix === held && out_valid === 1'b1, "R9 hold stable", out_pix, held);
      check(in_ready === 1'b0, "R9 no accept while held", {31'd0, in_ready}, 0);
    end
    fork
      begin repeat (2) @(posedge clk); #1 out_ready = 1; end
    join_none
    send(32'h2468_ACE0, 32'h0, 1, "R9 accept on drain");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule